// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block watches the four active-low control strobes of an asynchronous page-mode DRAM. The strobes are the row strobe, the column strobe, the write strobe and the output enable. It samples them on a fast system clock and labels each activity as one kind of memory cycle. It is meant to sit beside a memory controller as a protocol checker, or inside a behavioural memory model as its front end. It has no storage array.

The kind of cycle is decided by the order in which the strobe edges arrive. A row strobe falling while the column strobe is high opens a row and latches the row address. Each column strobe fall inside that row opens an access and latches a column. The position of the write strobe fall relative to the column strobe fall separates reads, early writes and read-modify-writes. A row strobe fall that finds the column strobe already low is a refresh. Whether it is a plain counter refresh, a hidden refresh, a test-mode entry or a self refresh depends on the write strobe, on the access that came before it and on how long the row strobe stays low.

Every finished access and every finished refresh period produces one event pulse. The pulse carries the cycle kind, the row, the column and the page-beat index. A data-drive indication shows when the device would put read data on its pins. A sticky two-bit flag records violations of the minimum row-precharge time and the minimum column-strobe pulse width, both measured in clock ticks.

Top module: `strobe_cycle_classifier`

## Requirements
- R1: After reset, `ev_valid`, `dq_drive` and `timing_err` are 0. Each finished access or refresh period raises `ev_valid` for exactly one clock, and two events never fall in adjacent clocks.
- R2: A row-strobe fall with the column strobe high latches `addr` as the row. Each column-strobe fall while the row strobe is low opens an access, latches `addr` as its column and takes the next page-beat index: 0 for the first fall in the row, then 1, 2 and so on. The access is reported when its column strobe rises, or when the row strobe rises first, with `ev_row` equal to the latched row.
- R3: If the write strobe is sampled low at the column-strobe fall, the access is an early write (`ev_kind` 2), and `dq_drive` stays 0 for the whole access.
- R4: If the write strobe falls during an access at least `T_CWD` samples after the column-strobe fall, and with `addr` unchanged for at least `T_AWD` samples, the access is a read-modify-write (`ev_kind` 3). `dq_drive` is 1 (with output enable low) from the column-strobe fall until the write strobe falls, and 0 after it.
- R5: An access with no write-strobe fall is a read (`ev_kind` 1) and drives `dq_drive` while output enable is low. A late write-strobe fall that misses either minimum of R4 is reported as indeterminate output (`ev_kind` 4).
- R6: A row-strobe low period with no column-strobe fall is reported at the row-strobe rise as a row-only refresh (`ev_kind` 5) carrying the latched row.
- R7: A row-strobe fall with the column strobe already low is a counter refresh (`ev_kind` 6) when the write strobe is high, and a test-mode entry (`ev_kind` 8) when the write strobe is low. Both report `ev_row` = 0.
- R8: A counter refresh whose row strobe stays low for at least `SELF_TICKS` samples is reported as self refresh (`ev_kind` 9).
- R9: If the column strobe is held low from an access through a row-strobe rise and a new row-strobe fall, that new period is a hidden refresh (`ev_kind` 7). A read's `dq_drive` stays 1 throughout it.
- R10: A row-strobe high time shorter than `T_RP` samples before a fall sets `timing_err[0]`. A column-strobe low time shorter than `T_CAS_MIN` samples at its rise sets `timing_err[1]`. Both bits hold until reset.
- R11: When the row and column strobes rise in the same sample during an open access, exactly one event results: the access, and no row-only refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| ev_valid | output | 1 | One-clock event pulse |
| ev_kind | output | 4 | Cycle kind code (see R3 to R8) |
| ev_row | output | AW | Row of the event, 0 for counter-based refresh |
| ev_col | output | AW | Column of an access event |
| ev_beat | output | BEAT_W | Page-beat index of an access event |
| dq_drive | output | 1 | Device would drive read data |
| timing_err | output | 2 | Sticky violations: bit0 precharge, bit1 column pulse |

## Verification
The row strobe and the column strobe can rise in the same clock. That one edge can close an open access and also end the row period, which could then be taken for a row that saw no column access. The bench raises both strobes on the same drive step during a read. It counts the events that follow and requires exactly one, of the read kind. In the same way, the hidden-refresh scenario checks that an access reported at a row-strobe rise still keeps the data-drive output asserted for the refresh period that follows.

// File: rtl/scc_pkg.sv
package scc_pkg;

    typedef enum logic [3:0] {
        EV_NONE       = 4'd0,
        EV_READ       = 4'd1,
        EV_EARLY_WR   = 4'd2,
        EV_RMW        = 4'd3,
        EV_WR_INDET   = 4'd4,
        EV_RAS_ONLY   = 4'd5,
        EV_CBR        = 4'd6,
        EV_HIDDEN     = 4'd7,
        EV_TEST_ENTRY = 4'd8,
        EV_SELF       = 4'd9
    } ev_kind_e;

    typedef enum logic [2:0] {
        PER_IDLE,
        PER_ROW,
        PER_CBR,
        PER_HIDDEN,
        PER_TEST
    } period_e;

    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic oe;
    } strobe_t;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic cas_rise;
        logic we_fall;
        logic addr_chg;
    } edge_t;

    localparam int N_AGE      = 4;
    localparam int AGE_RAS_HI = 0;
    localparam int AGE_RAS_LO = 1;
    localparam int AGE_CAS_LO = 2;
    localparam int AGE_ADDR   = 3;

    function automatic ev_kind_e access_kind(input logic early,
                                             input logic wfell,
                                             input logic rmw_ok);
        if (early)
            return EV_EARLY_WR;
        else if (wfell)
            return rmw_ok ? EV_RMW : EV_WR_INDET;
        else
            return EV_READ;
    endfunction

endpackage

// File: rtl/scc_strobe_sync.sv
module scc_strobe_sync
    import scc_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    output strobe_t       lvl,
    output edge_t         edg,
    output logic [AW-1:0] addr_s
);

    strobe_t       s_lvl;
    strobe_t       p_lvl;
    logic [AW-1:0] p_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_lvl  <= '{ras: 1'b1, cas: 1'b1, we: 1'b1, oe: 1'b1};
            p_lvl  <= '{ras: 1'b1, cas: 1'b1, we: 1'b1, oe: 1'b1};
            addr_s <= '0;
            p_addr <= '0;
        end else begin
            s_lvl  <= '{ras: ras_n, cas: cas_n, we: we_n, oe: oe_n};
            p_lvl  <= s_lvl;
            addr_s <= addr;
            p_addr <= addr_s;
        end
    end

    assign lvl          = s_lvl;
    assign edg.ras_fall = p_lvl.ras & ~s_lvl.ras;
    assign edg.ras_rise = ~p_lvl.ras & s_lvl.ras;
    assign edg.cas_fall = p_lvl.cas & ~s_lvl.cas;
    assign edg.cas_rise = ~p_lvl.cas & s_lvl.cas;
    assign edg.we_fall  = p_lvl.we & ~s_lvl.we;
    assign edg.addr_chg = (addr_s != p_addr);

    logic unused_oe;
    assign unused_oe = p_lvl.oe;

endmodule

// File: rtl/scc_age_ctr.sv
module scc_age_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    output logic [CW-1:0] age
);

    always_ff @(posedge clk) begin
        if (rst)
            age <= '1;
        else if (clear)
            age <= CW'(1);
        else if (age != '1)
            age <= age + 1'b1;
    end

endmodule

// File: rtl/scc_width_guard.sv
module scc_width_guard #(
    parameter int CW        = 16,
    parameter int T_RP      = 3,
    parameter int T_CAS_MIN = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_fall,
    input  logic          cas_rise,
    input  logic [CW-1:0] ras_hi_age,
    input  logic [CW-1:0] cas_lo_age,
    output logic [1:0]    err
);

    logic short_rp;
    logic short_cas;

    assign short_rp  = ras_fall && (ras_hi_age < CW'(T_RP));
    assign short_cas = cas_rise && (cas_lo_age < CW'(T_CAS_MIN));

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 2'b00;
        end else begin
            if (short_rp)
                err[0] <= 1'b1;
            if (short_cas)
                err[1] <= 1'b1;
        end
    end

endmodule

// File: rtl/strobe_cycle_classifier.sv
module strobe_cycle_classifier
    import scc_pkg::*;
#(
    parameter int AW         = 12,
    parameter int BEAT_W     = 8,
    parameter int T_RP       = 3,
    parameter int T_CAS_MIN  = 2,
    parameter int T_CWD      = 4,
    parameter int T_AWD      = 5,
    parameter int SELF_TICKS = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [AW-1:0]     addr,
    output logic              ev_valid,
    output logic [3:0]        ev_kind,
    output logic [AW-1:0]     ev_row,
    output logic [AW-1:0]     ev_col,
    output logic [BEAT_W-1:0] ev_beat,
    output logic              dq_drive,
    output logic [1:0]        timing_err
);

    localparam int CW = $clog2(SELF_TICKS + 1) + 1;

    strobe_t       lvl;
    edge_t         edg;
    logic [AW-1:0] addr_s;

    scc_strobe_sync #(.AW(AW)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .addr   (addr),
        .lvl    (lvl),
        .edg    (edg),
        .addr_s (addr_s)
    );

    // Interval counters: each restarts on its own edge and saturates.
    logic [N_AGE-1:0] age_clr;
    logic [CW-1:0]    age [N_AGE];

    assign age_clr[AGE_RAS_HI] = edg.ras_rise;
    assign age_clr[AGE_RAS_LO] = edg.ras_fall;
    assign age_clr[AGE_CAS_LO] = edg.cas_fall;
    assign age_clr[AGE_ADDR]   = edg.addr_chg;

    generate
        for (genvar g = 0; g < N_AGE; g++) begin : g_age
            scc_age_ctr #(.CW(CW)) u_age (
                .clk   (clk),
                .rst   (rst),
                .clear (age_clr[g]),
                .age   (age[g])
            );
        end
    endgenerate

    scc_width_guard #(.CW(CW), .T_RP(T_RP), .T_CAS_MIN(T_CAS_MIN)) u_guard (
        .clk        (clk),
        .rst        (rst),
        .ras_fall   (edg.ras_fall),
        .cas_rise   (edg.cas_rise),
        .ras_hi_age (age[AGE_RAS_HI]),
        .cas_lo_age (age[AGE_CAS_LO]),
        .err        (timing_err)
    );

    // Period and access state
    period_e           period_q;
    logic [AW-1:0]     row_q;
    logic              had_acc_q;
    logic [BEAT_W-1:0] beat_cnt_q;
    logic              acc_open_q;
    logic              acc_rep_q;
    logic              acc_early_q;
    logic              acc_wfell_q;
    logic              acc_rmw_q;
    logic [AW-1:0]     acc_col_q;
    logic [BEAT_W-1:0] acc_beat_q;

    logic acc_start;
    logic acc_done;
    logic late_we;
    logic rmw_window;

    assign acc_start  = edg.cas_fall && !lvl.ras && !edg.ras_fall && (period_q == PER_ROW);
    assign acc_done   = acc_open_q && !acc_rep_q &&
                        (edg.cas_rise || (edg.ras_rise && period_q == PER_ROW));
    assign late_we    = edg.we_fall && acc_open_q && !acc_early_q && !acc_wfell_q &&
                        !edg.cas_rise && !lvl.ras && (period_q == PER_ROW);
    assign rmw_window = (age[AGE_CAS_LO] >= CW'(T_CWD)) && (age[AGE_ADDR] >= CW'(T_AWD));

    // Event selection
    logic              nx_valid;
    ev_kind_e          nx_kind;
    logic [AW-1:0]     nx_row;
    logic [AW-1:0]     nx_col;
    logic [BEAT_W-1:0] nx_beat;

    always_comb begin
        nx_valid = 1'b0;
        nx_kind  = EV_NONE;
        nx_row   = '0;
        nx_col   = '0;
        nx_beat  = '0;
        if (acc_done) begin
            nx_valid = 1'b1;
            nx_kind  = access_kind(acc_early_q, acc_wfell_q, acc_rmw_q);
            nx_row   = row_q;
            nx_col   = acc_col_q;
            nx_beat  = acc_beat_q;
        end else if (edg.ras_rise) begin
            case (period_q)
                PER_ROW: begin
                    if (!had_acc_q) begin
                        nx_valid = 1'b1;
                        nx_kind  = EV_RAS_ONLY;
                        nx_row   = row_q;
                    end
                end
                PER_CBR: begin
                    nx_valid = 1'b1;
                    nx_kind  = (age[AGE_RAS_LO] >= CW'(SELF_TICKS)) ? EV_SELF : EV_CBR;
                end
                PER_HIDDEN: begin
                    nx_valid = 1'b1;
                    nx_kind  = EV_HIDDEN;
                end
                PER_TEST: begin
                    nx_valid = 1'b1;
                    nx_kind  = EV_TEST_ENTRY;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q    <= PER_IDLE;
            row_q       <= '0;
            had_acc_q   <= 1'b0;
            beat_cnt_q  <= '0;
            acc_open_q  <= 1'b0;
            acc_rep_q   <= 1'b0;
            acc_early_q <= 1'b0;
            acc_wfell_q <= 1'b0;
            acc_rmw_q   <= 1'b0;
            acc_col_q   <= '0;
            acc_beat_q  <= '0;
            ev_valid    <= 1'b0;
            ev_kind     <= EV_NONE;
            ev_row      <= '0;
            ev_col      <= '0;
            ev_beat     <= '0;
        end else begin
            ev_valid <= nx_valid;
            if (nx_valid) begin
                ev_kind <= nx_kind;
                ev_row  <= nx_row;
                ev_col  <= nx_col;
                ev_beat <= nx_beat;
            end

            if (edg.ras_fall) begin
                had_acc_q <= 1'b0;
                if (!lvl.cas) begin
                    if (!lvl.we)
                        period_q <= PER_TEST;
                    else if (acc_open_q)
                        period_q <= PER_HIDDEN;
                    else
                        period_q <= PER_CBR;
                end else begin
                    period_q   <= PER_ROW;
                    row_q      <= addr_s;
                    beat_cnt_q <= '0;
                end
            end else if (edg.ras_rise) begin
                period_q <= PER_IDLE;
            end

            if (acc_start) begin
                acc_open_q  <= 1'b1;
                acc_rep_q   <= 1'b0;
                acc_early_q <= !lvl.we;
                acc_wfell_q <= 1'b0;
                acc_rmw_q   <= 1'b0;
                acc_col_q   <= addr_s;
                acc_beat_q  <= beat_cnt_q;
                beat_cnt_q  <= beat_cnt_q + 1'b1;
                had_acc_q   <= 1'b1;
            end

            if (late_we) begin
                acc_wfell_q <= 1'b1;
                acc_rmw_q   <= rmw_window;
            end

            if (acc_done)
                acc_rep_q <= 1'b1;

            if (edg.cas_rise)
                acc_open_q <= 1'b0;
        end
    end

    assign dq_drive = acc_open_q && !acc_early_q && !acc_wfell_q && !lvl.oe;

endmodule

// File: rtl/scc_checker.sv
module scc_checker
    import scc_pkg::*;
#(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          ev_valid,
    input logic [3:0]    ev_kind,
    input logic [AW-1:0] ev_row,
    input logic          dq_drive,
    input logic [1:0]    timing_err,
    input logic          cas_s
);

    // R1: events are single-clock pulses and never back to back
    assert_event_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        ev_valid |=> !ev_valid);

    // R7: counter-based refresh kinds carry no row
    assert_refresh_row_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && (ev_kind == EV_CBR || ev_kind == EV_HIDDEN ||
                      ev_kind == EV_TEST_ENTRY || ev_kind == EV_SELF)) |-> (ev_row == '0));

    // R10: violation flags are sticky
    assert_rp_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        timing_err[0] |=> timing_err[0]);

    assert_cas_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        timing_err[1] |=> timing_err[1]);

    // R9: data is driven only while the column strobe was sampled low
    assert_drive_needs_cas_R9: assert property (@(posedge clk) disable iff (rst)
        dq_drive |-> !$past(cas_s));

    // R3: an early write never had data driven in the clock before its report
    assert_early_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == EV_EARLY_WR) |-> !$past(dq_drive));

endmodule

bind strobe_cycle_classifier scc_checker #(.AW(AW)) u_scc_checker (
    .clk        (clk),
    .rst        (rst),
    .ev_valid   (ev_valid),
    .ev_kind    (ev_kind),
    .ev_row     (ev_row),
    .dq_drive   (dq_drive),
    .timing_err (timing_err),
    .cas_s      (lvl.cas)
);

// File: tb/tb_strobe_cycle_classifier.sv
module tb_strobe_cycle_classifier;

    localparam int AW = 12;
    localparam int BW = 8;
    // kind codes from the requirements
    localparam int K_READ = 1, K_EW = 2, K_RMW = 3, K_INDET = 4, K_RONLY = 5;
    localparam int K_CBR = 6, K_HIDDEN = 7, K_TEST = 8, K_SELF = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ev_valid;
    logic [3:0]    ev_kind;
    logic [AW-1:0] ev_row, ev_col;
    logic [BW-1:0] ev_beat;
    logic          dq_drive;
    logic [1:0]    timing_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    strobe_cycle_classifier #(.AW(AW), .BEAT_W(BW)) dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_row(ev_row), .ev_col(ev_col), .ev_beat(ev_beat),
        .dq_drive(dq_drive), .timing_err(timing_err)
    );

    // event log
    int ev_n = 0;
    int lg_kind [64];
    int lg_row  [64];
    int lg_col  [64];
    int lg_beat [64];

    always @(negedge clk) begin
        if (!rst && ev_valid) begin
            lg_kind[ev_n % 64] = int'(ev_kind);
            lg_row[ev_n % 64]  = int'(ev_row);
            lg_col[ev_n % 64]  = int'(ev_col);
            lg_beat[ev_n % 64] = int'(ev_beat);
            ev_n++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_row(input int row);
        addr = AW'(row);
        step(1);
        ras_n = 1'b0;
        step(2);
    endtask

    task automatic close_row();
        ras_n = 1'b1;
        step(4);
    endtask

    task automatic t_reset();
        chk("R1 reset ev_valid", int'(ev_valid), 0);
        chk("R1 reset dq_drive", int'(dq_drive), 0);
        chk("R1 reset timing_err", int'(timing_err), 0);
    endtask

    task automatic t_read();
        int base = ev_n;
        open_row(12'h1A3);
        addr = 12'h05C;
        step(1);
        cas_n = 1'b0;
        step(3);
        chk("R5 read drives data", int'(dq_drive), 1);
        oe_n = 1'b1;
        step(2);
        chk("R5 read output enable off", int'(dq_drive), 0);
        oe_n = 1'b0;
        cas_n = 1'b1;
        step(2);
        close_row();
        chk("R1 read one event", ev_n - base, 1);
        chk("R5 read kind", lg_kind[base % 64], K_READ);
        chk("R2 read row", lg_row[base % 64], 12'h1A3);
        chk("R2 read col", lg_col[base % 64], 12'h05C);
    endtask

    task automatic t_page();
        int base = ev_n;
        open_row(12'h2F0);
        for (int i = 0; i < 3; i++) begin
            addr = AW'(12'h010 + i);
            step(1);
            cas_n = 1'b0;
            step(3);
            cas_n = 1'b1;
            step(2);
        end
        close_row();
        chk("R2 page event count", ev_n - base, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R2 page beat", lg_beat[(base + i) % 64], i);
            chk("R2 page col", lg_col[(base + i) % 64], 12'h010 + i);
            chk("R2 page row", lg_row[(base + i) % 64], 12'h2F0);
        end
    endtask

    task automatic t_early();
        int base = ev_n;
        int seen = 0;
        open_row(12'h044);
        addr = 12'h123;
        we_n = 1'b0;
        step(1);
        cas_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step(1);
            if (dq_drive) seen++;
        end
        cas_n = 1'b1;
        we_n = 1'b1;
        step(2);
        close_row();
        chk("R3 early write no drive", seen, 0);
        chk("R3 early write kind", lg_kind[base % 64], K_EW);
    endtask

    task automatic t_rmw();
        int base = ev_n;
        open_row(12'h300);
        addr = 12'h0AA;
        step(1);
        cas_n = 1'b0;
        step(3);
        chk("R4 rmw drives before write", int'(dq_drive), 1);
        step(3);
        we_n = 1'b0;
        step(3);
        chk("R4 rmw stops after write", int'(dq_drive), 0);
        cas_n = 1'b1;
        we_n = 1'b1;
        step(2);
        close_row();
        chk("R4 rmw kind", lg_kind[base % 64], K_RMW);
    endtask

    task automatic t_indet_cas();
        int base = ev_n;
        open_row(12'h301);
        addr = 12'h0BB;
        step(6);
        cas_n = 1'b0;
        step(2);
        we_n = 1'b0;
        step(3);
        cas_n = 1'b1;
        we_n = 1'b1;
        step(2);
        close_row();
        chk("R5 indet short cas gap", lg_kind[base % 64], K_INDET);
    endtask

    task automatic t_indet_addr();
        int base = ev_n;
        open_row(12'h302);
        addr = 12'h0CC;
        step(1);
        cas_n = 1'b0;
        step(4);
        addr = 12'h7FF;
        step(2);
        we_n = 1'b0;
        step(3);
        cas_n = 1'b1;
        we_n = 1'b1;
        step(2);
        close_row();
        chk("R5 indet fresh address", lg_kind[base % 64], K_INDET);
        chk("R2 indet col latched at fall", lg_col[base % 64], 12'h0CC);
    endtask

    task automatic t_ras_only();
        int base = ev_n;
        open_row(12'h5A5);
        step(3);
        close_row();
        chk("R6 row-only count", ev_n - base, 1);
        chk("R6 row-only kind", lg_kind[base % 64], K_RONLY);
        chk("R6 row-only row", lg_row[base % 64], 12'h5A5);
    endtask

    task automatic t_cbr();
        int base = ev_n;
        addr = 12'h777;
        cas_n = 1'b0;
        step(2);
        ras_n = 1'b0;
        step(5);
        ras_n = 1'b1;
        step(3);
        cas_n = 1'b1;
        step(4);
        chk("R7 cbr kind", lg_kind[base % 64], K_CBR);
        chk("R7 cbr row zero", lg_row[base % 64], 0);
    endtask

    task automatic t_test_entry();
        int base = ev_n;
        we_n = 1'b0;
        cas_n = 1'b0;
        step(2);
        ras_n = 1'b0;
        step(4);
        ras_n = 1'b1;
        step(3);
        cas_n = 1'b1;
        we_n = 1'b1;
        step(4);
        chk("R7 test entry kind", lg_kind[base % 64], K_TEST);
    endtask

    task automatic t_self();
        int base = ev_n;
        cas_n = 1'b0;
        step(2);
        ras_n = 1'b0;
        step(10010);
        ras_n = 1'b1;
        step(3);
        cas_n = 1'b1;
        step(4);
        chk("R8 self refresh kind", lg_kind[base % 64], K_SELF);
    endtask

    task automatic t_hidden();
        int base = ev_n;
        int drop = 0;
        open_row(12'h0F1);
        addr = 12'h033;
        step(1);
        cas_n = 1'b0;
        step(4);
        ras_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(1);
            if (!dq_drive) drop++;
        end
        ras_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step(1);
            if (!dq_drive) drop++;
        end
        ras_n = 1'b1;
        step(3);
        chk("R9 data held through hidden refresh", drop, 0);
        cas_n = 1'b1;
        step(4);
        chk("R9 hidden event count", ev_n - base, 2);
        chk("R9 access before hidden", lg_kind[base % 64], K_READ);
        chk("R9 hidden kind", lg_kind[(base + 1) % 64], K_HIDDEN);
    endtask

    task automatic t_same_rise();
        int base = ev_n;
        open_row(12'h222);
        addr = 12'h011;
        step(1);
        cas_n = 1'b0;
        step(4);
        cas_n = 1'b1;
        ras_n = 1'b1;
        step(5);
        chk("R11 same-sample rise one event", ev_n - base, 1);
        chk("R11 same-sample rise kind", lg_kind[base % 64], K_READ);
    endtask

    task automatic t_timing();
        chk("R10 clean before violations", int'(timing_err), 0);
        open_row(12'h001);
        ras_n = 1'b1;
        step(1);
        ras_n = 1'b0;
        step(3);
        close_row();
        chk("R10 short precharge flag", int'(timing_err), 1);
        open_row(12'h002);
        addr = 12'h004;
        step(1);
        cas_n = 1'b0;
        step(1);
        cas_n = 1'b1;
        step(3);
        close_row();
        chk("R10 short column pulse flag", int'(timing_err), 3);
        step(10);
        chk("R10 flags sticky", int'(timing_err), 3);
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(2);
        chk("R10 reset clears flags", int'(timing_err), 0);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(2);
        t_reset();
        t_read();
        t_page();
        t_early();
        t_rmw();
        t_indet_cas();
        t_indet_addr();
        t_ras_only();
        t_cbr();
        t_test_entry();
        t_hidden();
        t_same_rise();
        t_self();
        t_timing();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule